// File: doc/BRIEF.md
# Peripheral Request Channel Router

This block sits between a set of peripheral request lines and a bank of DMA channels. For each request line it holds a small routing entry: an enable flag and a target channel index. While an entry is enabled, its request line is steered to the chosen channel's request output. When several enabled entries name the same channel, their requests merge by OR. Software programs the entries through a simple word-wide register port. Because the request numbers are split across two address windows of 64 entries each, up to 128 request lines can be routed.

The same port also exposes a read-only interrupt summary word. Each channel reports an interrupt level, and the word carries one bit per channel. A single combined interrupt output is raised whenever any channel reports. A summary bit drops as soon as its channel stops reporting, which happens when that channel's own status is cleared. The channel engines themselves are outside this block.

Top module: `chan_map`

## Requirements
- R1: After reset every routing entry is disabled with channel index 0, every `chan_req` bit is 0 and `rd_data` is 0.
- R2: A write to an entry stores `wdata[7]` as the enable flag and `wdata[4:0]` as the channel index. A read of the entry returns the flag in bit 7 and the index in bits [4:0], with all other bits 0.
- R3: The entry of request n (n < 64) is at byte address 0x100 + 4n. The entry of request n (64 <= n < 128) is at 0x1100 + 4(n-64).
- R4: `chan_req[c]` is high, in the same cycle, exactly when at least one request line whose entry is enabled and names channel c is high. Several such lines combine by OR.
- R5: A request whose entry is disabled drives no channel, whatever its stored index. Writing 0 to an entry removes its route.
- R6: A read at address 0xF0 returns `chan_irq` as sampled at the read's clock edge, bit i for channel i, with upper bits 0.
- R7: `irq_out` is high exactly while at least one `chan_irq` bit is high.
- R8: A write to address 0xF0 has no effect: a following summary read still returns `chan_irq`, and no entry changes.
- R9: `rd_data` is updated on the clock edge where `rd_en` is high and holds otherwise. Reads of unmapped or misaligned addresses (addr[1:0] not 0) return 0, and writes to them are ignored.
- R10: When a read and a write target the same entry in one cycle, the read returns the value the entry held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (16) | Byte address of the register access |
| wdata | input | DW (32) | Write data |
| rd_data | output | DW (32) | Read data, valid the cycle after `rd_en` |
| req_in | input | NREQ (128) | Peripheral request lines |
| chan_req | output | NCH (32) | Routed request per channel |
| chan_irq | input | NCH (32) | Interrupt level per channel |
| irq_out | output | 1 | High while any channel interrupts |

## Verification
Two of the block's functions can coincide in one cycle. The first case is a register read and a write aimed at the same entry. The bench raises both strobes on one edge and expects the old entry value, then reads again and expects the new value. The second case is a routing update while the affected request line is held high. The bench holds the request steady across the write and compares `chan_req` against its own model before and after the edge, so the route must move from the old channel to the new one without lingering on the old one.

// File: rtl/chan_map.sv
module chan_map #(
  parameter int NREQ = 128,
  parameter int NCH  = 32,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_data,
  input  logic [NREQ-1:0] req_in,
  output logic [NCH-1:0]  chan_req,
  input  logic [NCH-1:0]  chan_irq,
  output logic            irq_out
);
  localparam int IDXW   = $clog2(NREQ);
  localparam int CHF    = 5;
  localparam int EN_BIT = 7;
  localparam int unsigned LO_PAGE = 'h01;
  localparam int unsigned HI_PAGE = 'h11;
  localparam int unsigned SUM_ADR = 'hF0;

  logic [NREQ-1:0] en_q;
  logic [CHF-1:0]  ch_q [NREQ];

  logic       lo_win, hi_win, aligned, ent_hit, sum_hit;
  logic [6:0] raw_idx;
  logic [IDXW-1:0] idx;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  assign lo_win  = addr[AW-1:8] == LO_PAGE[AW-9:0];
  assign hi_win  = addr[AW-1:8] == HI_PAGE[AW-9:0];
  assign aligned = addr[1:0] == 2'b00;
  assign raw_idx = {hi_win, addr[7:2]};
  assign idx     = raw_idx[IDXW-1:0];
  assign ent_hit = (lo_win | hi_win) & aligned & (int'(raw_idx) < NREQ);
  assign sum_hit = addr == SUM_ADR[AW-1:0];

  wire unused_wdata = &{1'b0, wdata[DW-1:EN_BIT+1], wdata[EN_BIT-1:CHF]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int n = 0; n < NREQ; n++) ch_q[n] <= '0;
    end else if (wr_en && ent_hit) begin
      en_q[idx] <= wdata[EN_BIT];
      ch_q[idx] <= wdata[CHF-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sum_hit) begin
      rd_mux[NCH-1:0] = chan_irq;
    end else if (ent_hit) begin
      rd_mux[EN_BIT]    = en_q[idx];
      rd_mux[CHF-1:0]   = ch_q[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_mux;
  end
  assign rd_data = rdata_q;

  always_comb begin
    chan_req = '0;
    for (int n = 0; n < NREQ; n++)
      if (en_q[n] && req_in[n] && (int'(ch_q[n]) < NCH))
        chan_req[ch_q[n]] = 1'b1;
  end

  assign irq_out = |chan_irq;
endmodule

// File: rtl/chan_map_chk.sv
module chan_map_chk #(
  parameter int NREQ = 128,
  parameter int NCH  = 32,
  parameter int AW   = 16,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   rd_data,
  input logic [NREQ-1:0] req_in,
  input logic [NCH-1:0]  chan_req,
  input logic [NCH-1:0]  chan_irq,
  input logic            irq_out
);
  logic [DW-1:0] irq_word;
  always_comb begin
    irq_word = '0;
    irq_word[NCH-1:0] = chan_irq;
  end

  wire unused_wr = &{1'b0, wr_en};

  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq != '0) |-> irq_out);
  p_irq_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq == '0) |-> !irq_out);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[1:0] != 2'b00) |=> rd_data == '0);
  p_sum_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'('hF0)) |=> rd_data == $past(irq_word));
  p_idle_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in == '0) |-> chan_req == '0);
  p_req_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chan_req) <= $countones(req_in));
endmodule

bind chan_map chan_map_chk #(.NREQ(NREQ), .NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .req_in(req_in), .chan_req(chan_req),
  .chan_irq(chan_irq), .irq_out(irq_out)
);

// File: tb/tb_chan_map.sv
module tb_chan_map;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0, rd_en = 0;
  logic [15:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rd_data;
  logic [127:0] req_in = '0;
  logic [31:0]  chan_req;
  logic [31:0]  chan_irq = '0;
  logic         irq_out;

  int total = 0, bad = 0;
  bit m_en [128];
  logic [4:0] m_ch [128];

  chan_map dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .req_in(req_in),
    .chan_req(chan_req), .chan_irq(chan_irq), .irq_out(irq_out));

  always #5 clk = ~clk;

  function automatic logic [15:0] ent_addr(int n);
    if (n < 64) return 16'(32'h100 + 4 * n);
    return 16'(32'h1100 + 4 * (n - 64));
  endfunction

  function automatic logic [31:0] exp_route(logic [127:0] r);
    logic [31:0] o = '0;
    for (int n = 0; n < 128; n++) if (m_en[n] && r[n]) o[m_ch[n]] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] exp_entry(int n);
    logic [31:0] w = '0;
    w[7] = m_en[n]; w[4:0] = m_ch[n];
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_ent(int n, logic [31:0] d);
    wr(ent_addr(n), d);
    m_en[n] = d[7]; m_ch[n] = d[4:0];
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk); @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, old;
    void'($urandom(32'd4711));
    for (int n = 0; n < 128; n++) begin m_en[n] = 0; m_ch[n] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 chan_req", chan_req, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R7 irq idle", {31'b0, irq_out}, 32'h0);
    rd(ent_addr(100), d); chk("R1 entry", d, 32'h0);

    // R2 R3 directed entries at window edges
    wr_ent(0, 32'h83); wr_ent(63, 32'h9F); wr_ent(64, 32'h80); wr_ent(127, 32'hFFFF_FF91);
    rd(16'h0100, d); chk("R3 n=0", d, 32'h83);
    rd(16'h01FC, d); chk("R3 n=63", d, 32'h9F);
    rd(16'h1100, d); chk("R3 n=64", d, 32'h80);
    rd(16'h11FC, d); chk("R2 junk bits", d, 32'h91);

    // R4 routing and OR merge
    @(negedge clk); req_in = '0; req_in[0] = 1; #1;
    chk("R4 single", chan_req, 32'h8);
    wr_ent(5, 32'h83);
    @(negedge clk); req_in[5] = 1; req_in[127] = 1; #1;
    chk("R4 merge", chan_req, exp_route(req_in));
    @(negedge clk); req_in[0] = 0; #1;
    chk("R4 merge one left", chan_req, 32'h0002_0008);

    // R5 zero write and disabled index
    wr_ent(5, 32'h0); wr_ent(0, 32'h0);
    #1; chk("R5 zero write", chan_req, 32'h0002_0000);
    wr_ent(127, 32'h11); #1;
    chk("R5 disabled", chan_req, 32'h0);

    // R10 simultaneous read and write, request held through update
    wr_ent(40, 32'h8A);
    @(negedge clk); req_in = '0; req_in[40] = 1; #1;
    chk("R10 route before", chan_req, 32'h400);
    old = exp_entry(40);
    @(negedge clk); wr_en = 1; rd_en = 1; addr = ent_addr(40); wdata = 32'h8C;
    @(posedge clk); @(negedge clk); wr_en = 0; rd_en = 0;
    m_en[40] = 1; m_ch[40] = 5'h0C;
    chk("R10 old value", rd_data, old);
    chk("R10 route after", chan_req, 32'h1000);
    rd(ent_addr(40), d); chk("R10 new value", d, 32'h8C);

    // R6 R7 R8 summary
    @(negedge clk); chan_irq = 32'h8000_0001; #1;
    chk("R7 irq set", {31'b0, irq_out}, 32'h1);
    rd(16'h00F0, d); chk("R6 summary", d, 32'h8000_0001);
    wr(16'h00F0, 32'h0000_00FF);
    rd(16'h00F0, d); chk("R8 summary ro", d, 32'h8000_0001);
    rd(ent_addr(40), d); chk("R8 entry intact", d, 32'h8C);
    @(negedge clk); chan_irq = '0; #1;
    chk("R7 irq clear", {31'b0, irq_out}, 32'h0);

    // R9 hold and unmapped
    rd(16'h00F0, d);
    @(negedge clk); chan_irq = 32'h55; @(negedge clk);
    chk("R9 hold", rd_data, 32'h0);
    rd(16'h0101, d); chk("R9 misaligned", d, 32'h0);
    rd(16'h0200, d); chk("R9 unmapped", d, 32'h0);
    wr(16'h0122, 32'h9F);
    rd(16'h0120, d); chk("R9 misaligned write", d, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int n;
      n = int'($urandom_range(0, 127));
      wr_ent(n, $urandom);
      @(negedge clk);
      req_in = {$urandom, $urandom, $urandom, $urandom};
      chan_irq = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      #1;
      chk("R4 random route", chan_req, exp_route(req_in));
      chk("R7 random irq", {31'b0, irq_out}, {31'b0, chan_irq != 0});
      if (it % 8 == 0) begin
        int k;
        k = int'($urandom_range(0, 127));
        rd(ent_addr(k), d); chk("R2 random readback", d, exp_entry(k));
        rd(16'h00F0, d); chk("R6 random summary", d, chan_irq);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule